// File: doc/BRIEF.md
# Third-Bit Oversampled UART

This block is a half-duplex serial port for 8N1 framing. One timing tick is produced for every third of a bit period by a parameterized clock divider, and everything in the block advances on those ticks. The default settings give 2400 baud. The receiver watches the line only while it is idle. When it finds the line low on a tick, it treats that as a start bit. It reads each data bit one tick into that bit's three-tick window, least significant bit first. It then stops two ticks into the stop bit. Finishing early in the stop bit lets it lock onto the next start edge without drift carrying over from one byte to the next.

The transmitter sends a low start bit, eight data bits least significant first, and a high stop bit. Each of these lasts three ticks. If the last completed operation was a reception, the transmitter first waits two extra ticks so that the far end has time to turn the line around. Only one direction is active at a time.

A system above the block can ask for the idle output line to be held low, for example to signal an interrupt to a host. The next detected start bit, or the next accepted transmission, releases the line back to high. Received bytes leave through a valid/ready handshake. Bytes to send enter through a valid/ready handshake, and a busy flag covers the whole frame.

Top module: `tri_tick_uart`

## Requirements
- R1: While reset is asserted and directly after it, `txd` is 1, `rx_valid` is 0 and `tx_busy` is 0.
- R2: `rxd` passes through a two-flop synchronizer before any use. The receiver looks for a start bit only on tick cycles, and only when it is not in a frame, the transmitter is idle and no received byte is waiting. A synchronized 0 on such a tick starts a frame.
- R3: Data bit k (k = 0..7, LSB first) is sampled on tick number 4+3k after the start-detect tick. The byte appears on `rx_data` with bit 0 being the first bit received.
- R4: A frame ends on tick 29 after the start-detect tick, two ticks into the stop bit. `rx_valid` rises on the next clock, and the receiver may detect a new start bit on any later tick.
- R5: Once `rx_valid` is 1, it and `rx_data` stay unchanged until a clock edge where `rx_ready` is 1. After that edge `rx_valid` is 0.
- R6: An accepted byte is sent as start 0, data bits LSB first, then stop 1. Each bit lasts three ticks. Without a turnaround gap the start bit begins on the first tick after acceptance. `tx_busy` is 1 from the acceptance edge until the third tick of the stop bit.
- R7: When the last completed operation was a reception, the start bit begins on the third tick after acceptance instead of the first, and `txd` stays 1 until then. Accepting a byte clears the pending turnaround.
- R8: A 1 on `pull_low` at a clock edge makes `txd` 0 while the transmitter is idle. A detected start bit or an accepted byte releases the line back to 1 from the next clock.
- R9: `tx_ready` is 1 only when the transmitter is idle, the receiver is not in a frame and the current cycle is not a tick cycle. A byte is accepted on an edge where both `tx_valid` and `tx_ready` are 1. A low on `rxd` while `tx_busy` is 1 starts no reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial receive line, asynchronous, idle high |
| txd | output | 1 | Serial transmit line, idle high |
| rx_data | output | DATA_BITS | Last received byte |
| rx_valid | output | 1 | Received byte waiting |
| rx_ready | input | 1 | Consumer takes the received byte |
| tx_data | input | DATA_BITS | Byte to transmit |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_ready | output | 1 | Transmitter will accept on this edge |
| tx_busy | output | 1 | Transmit frame in progress, including any turnaround gap |
| pull_low | input | 1 | Request to hold the idle line low |

## Verification
The assertions assume that `tx_valid` is raised only while `tx_ready` is 1 and that `pull_low` is a short pulse. They also assume the far end never starts a new frame earlier than one full frame after the previous start edge. With those assumptions, the half-duplex rule and the hold-until-ready rule follow from the control logic. The stimulus changes `rxd` only at whole multiples of a bit period, with at least one stop bit between bytes. It checks `tx_ready` before offering a byte and pulses `pull_low` for a single cycle. The only low it places on `rxd` while a frame is being transmitted is a deliberate short one, and it ends well before that frame does.

// File: rtl/uart3_pkg.sv
package uart3_pkg;
   localparam int unsigned TICKS_PER_BIT = 3;

   typedef enum logic [1:0] {
      RX_HUNT  = 2'd0,
      RX_FRAME = 2'd1
   } rx_state_e;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_LEAD = 2'd1,
      TX_SEND = 2'd2
   } tx_state_e;
endpackage

// File: rtl/uart3_ticker.sv
module uart3_ticker #(
   parameter int unsigned DIV = 555
)(
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == LAST);

   // R6
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/uart3_rx.sv
module uart3_rx
   import uart3_pkg::*;
#(
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxd_async,
   input  logic                 hunt_ok,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   input  logic                 rx_ready,
   output logic                 active,
   output logic                 start_seen,
   output logic                 done
);
   localparam int unsigned STOP_SLOT = DATA_BITS + 1;
   localparam int unsigned SLOT_W    = $clog2(STOP_SLOT + 1);
   localparam logic [SLOT_W-1:0] STOP_IDX  = SLOT_W'(STOP_SLOT);
   localparam logic [SLOT_W-1:0] LAST_DATA = SLOT_W'(DATA_BITS);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   line_s;
   rx_state_e              state_q;
   logic [SLOT_W-1:0]      slot_q;
   logic [1:0]             phase_q;
   logic [DATA_BITS-1:0]   shift_q;
   logic                   valid_q;
   logic                   sample_now;

   // metastability guard on the asynchronous line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_async};
   end
   assign line_s = sync_q[SYNC_STAGES-1];

   assign start_seen = (state_q == RX_HUNT) && tick && hunt_ok && !valid_q && !line_s;
   // position (slot, phase 0) moving to phase 1 is the entry of the middle third
   assign sample_now = (state_q == RX_FRAME) && tick && (phase_q == 2'd0)
                       && (slot_q != '0) && (slot_q <= LAST_DATA);
   // two thirds into the stop bit
   assign done       = (state_q == RX_FRAME) && tick && (phase_q == 2'd1)
                       && (slot_q == STOP_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RX_HUNT;
         slot_q  <= '0;
         phase_q <= 2'd0;
         shift_q <= '0;
         valid_q <= 1'b0;
      end else begin
         if (start_seen) begin
            state_q <= RX_FRAME;
            slot_q  <= '0;
            phase_q <= 2'd0;
         end else if ((state_q == RX_FRAME) && tick) begin
            if (done) state_q <= RX_HUNT;
            if (phase_q == 2'd2) begin
               phase_q <= 2'd0;
               slot_q  <= slot_q + 1'b1;
            end else begin
               phase_q <= phase_q + 1'b1;
            end
         end
         if (sample_now) shift_q <= {line_s, shift_q[DATA_BITS-1:1]};
         if (done)          valid_q <= 1'b1;
         else if (rx_ready) valid_q <= 1'b0;
      end
   end

   assign rx_data  = shift_q;
   assign rx_valid = valid_q;
   assign active   = (state_q == RX_FRAME);

   // R5
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));
   // R4
   rx_done_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_valid) |-> $past(tick) && !active);
endmodule

// File: rtl/uart3_tx.sv
module uart3_tx
   import uart3_pkg::*;
#(
   parameter int unsigned DATA_BITS  = 8,
   parameter int unsigned TURN_TICKS = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic [DATA_BITS-1:0] tx_data,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   input  logic                 rx_idle,
   input  logic                 turn_pending,
   input  logic                 idle_level,
   output logic                 busy,
   output logic                 line,
   output logic                 accept
);
   localparam int unsigned FRAME_W   = DATA_BITS + 2;
   localparam int unsigned STOP_SLOT = DATA_BITS + 1;
   localparam int unsigned SLOT_W    = $clog2(STOP_SLOT + 1);
   localparam int unsigned LEAD_W    = (TURN_TICKS > 0) ? $clog2(TURN_TICKS + 1) : 1;
   localparam logic [SLOT_W-1:0] STOP_IDX = SLOT_W'(STOP_SLOT);
   localparam logic [LEAD_W-1:0] LEAD_GAP = LEAD_W'(TURN_TICKS);

   tx_state_e            state_q;
   logic [LEAD_W-1:0]    lead_q;
   logic [SLOT_W-1:0]    slot_q;
   logic [1:0]           phase_q;
   logic [FRAME_W-1:0]   frame_q;
   logic [FRAME_W-1:0]   frame_load;
   logic                 bit_q;

   assign frame_load[0]         = 1'b0;
   assign frame_load[FRAME_W-1] = 1'b1;
   generate
      for (genvar i = 0; i < DATA_BITS; i++) begin : g_frame
         assign frame_load[i+1] = tx_data[i];
      end
   endgenerate

   assign busy     = (state_q != TX_IDLE);
   assign tx_ready = !busy && rx_idle && !tick;
   assign accept   = tx_valid && tx_ready;
   assign line     = busy ? bit_q : idle_level;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         lead_q  <= '0;
         slot_q  <= '0;
         phase_q <= 2'd0;
         frame_q <= '1;
         bit_q   <= 1'b1;
      end else begin
         case (state_q)
            TX_IDLE: if (accept) begin
               state_q <= TX_LEAD;
               lead_q  <= turn_pending ? LEAD_GAP : '0;
               frame_q <= frame_load;
               bit_q   <= 1'b1;
            end
            TX_LEAD: if (tick) begin
               if (lead_q == '0) begin
                  state_q <= TX_SEND;
                  bit_q   <= frame_q[0];
                  frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                  slot_q  <= '0;
                  phase_q <= 2'd0;
               end else begin
                  lead_q <= lead_q - 1'b1;
               end
            end
            TX_SEND: if (tick) begin
               if (phase_q == 2'd2) begin
                  phase_q <= 2'd0;
                  if (slot_q == STOP_IDX) begin
                     state_q <= TX_IDLE;
                  end else begin
                     slot_q  <= slot_q + 1'b1;
                     bit_q   <= frame_q[0];
                     frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
                  end
               end else begin
                  phase_q <= phase_q + 1'b1;
               end
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   // R6
   stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(line));
   // R6
   line_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) && !$past(tick) |-> $stable(line));
endmodule

// File: rtl/tri_tick_uart.sv
module tri_tick_uart #(
   parameter int unsigned CLK_HZ      = 4_000_000,
   parameter int unsigned BAUD        = 2400,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TURN_TICKS  = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rxd,
   output logic                 txd,
   output logic [DATA_BITS-1:0] rx_data,
   output logic                 rx_valid,
   input  logic                 rx_ready,
   input  logic [DATA_BITS-1:0] tx_data,
   input  logic                 tx_valid,
   output logic                 tx_ready,
   output logic                 tx_busy,
   input  logic                 pull_low
);
   localparam int unsigned TICK_DIV = CLK_HZ / (BAUD * uart3_pkg::TICKS_PER_BIT);

   generate
      if (TICK_DIV < 2) begin : g_bad_div
         $error("tri_tick_uart: clock too slow for three ticks per bit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("tri_tick_uart: synchronizer needs at least two stages");
      end
      if (DATA_BITS < 2 || DATA_BITS > 14) begin : g_bad_width
         $error("tri_tick_uart: DATA_BITS out of range");
      end
   endgenerate

   logic tick;
   logic rx_active;
   logic start_seen;
   logic rx_done;
   logic tx_accept;
   logic hold_q;
   logic turn_q;

   uart3_ticker #(.DIV(TICK_DIV)) u_ticker (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   uart3_rx #(.DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .rxd_async  (rxd),
      .hunt_ok    (!tx_busy),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_ready   (rx_ready),
      .active     (rx_active),
      .start_seen (start_seen),
      .done       (rx_done)
   );

   uart3_tx #(.DATA_BITS(DATA_BITS), .TURN_TICKS(TURN_TICKS)) u_tx (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .tx_data      (tx_data),
      .tx_valid     (tx_valid),
      .tx_ready     (tx_ready),
      .rx_idle      (!rx_active),
      .turn_pending (turn_q),
      .idle_level   (!hold_q),
      .busy         (tx_busy),
      .line         (txd),
      .accept       (tx_accept)
   );

   // turnaround owed after a completed reception
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         turn_q <= 1'b0;
      else if (tx_accept) turn_q <= 1'b0;
      else if (rx_done)   turn_q <= 1'b1;
   end

   // held-low idle line, released by line activity
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       hold_q <= 1'b0;
      else if (start_seen || tx_accept) hold_q <= 1'b0;
      else if (pull_low)                hold_q <= 1'b1;
   end

   // R9
   half_duplex_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> !rx_active);
   // R8
   release_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_active) |-> txd);
endmodule

// File: tb/tb_tri_tick_uart.sv
module tb_tri_tick_uart;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 36000;
   localparam int BAUD       = 2400;
   localparam int DIV        = CLK_HZ / (BAUD * 3);
   localparam int BITLEN     = 3 * DIV;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       rxd;
   logic       txd;
   logic [7:0] rx_data;
   logic       rx_valid;
   logic       rx_ready;
   logic [7:0] tx_data;
   logic       tx_valid;
   logic       tx_ready;
   logic       tx_busy;
   logic       pull_low;

   int checks = 0;
   int errors = 0;
   bit cmp_en = 1'b0;

   tri_tick_uart #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) dut (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
      .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .tx_busy(tx_busy), .pull_low(pull_low)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference (tick indices, not state machines)
   int       m_cyc, m_tk, m_t0, m_start;
   bit       m_s1, m_s2;
   bit       m_rx_on, m_valid, m_tx_on, m_line, m_turn, m_hold, m_gap;
   bit [7:0] m_shift;
   bit [9:0] m_frame;
   bit       tk_now, rdy, det, acc;
   int       d, rel;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cyc = 0; m_tk = 0; m_t0 = 0; m_start = 0;
         m_s1 = 1; m_s2 = 1;
         m_rx_on = 0; m_valid = 0; m_tx_on = 0; m_line = 1;
         m_turn = 0; m_hold = 0; m_gap = 0; m_shift = 0; m_frame = '1;
      end else begin
         tk_now = ((m_cyc % DIV) == DIV - 1);
         rdy    = !m_tx_on && !m_rx_on && !tk_now;
         acc    = tx_valid && rdy;
         det    = tk_now && !m_rx_on && !m_tx_on && !m_valid && !m_s2;
         if (m_valid && rx_ready) m_valid = 0;
         if (tk_now && m_rx_on) begin
            d = m_tk - m_t0;
            if (d >= 4 && d <= 25 && ((d - 4) % 3) == 0) m_shift = {m_s2, m_shift[7:1]};
            if (d == 29) begin m_rx_on = 0; m_valid = 1; m_turn = 1; end
         end
         if (tk_now && m_tx_on) begin
            rel = m_tk - m_start;
            if (rel >= 0 && rel < 30 && (rel % 3) == 0) m_line = m_frame[rel/3];
            if (rel == 30) m_tx_on = 0;
         end
         if (det) begin m_rx_on = 1; m_t0 = m_tk; end
         if (acc) begin
            m_tx_on = 1; m_line = 1; m_frame = {1'b1, tx_data, 1'b0};
            m_gap = m_turn; m_start = m_tk + (m_turn ? 2 : 0); m_turn = 0;
         end
         if (det || acc) m_hold = 0;
         else if (pull_low) m_hold = 1;
         m_s2 = m_s1; m_s1 = rxd;
         if (tk_now) m_tk++;
         m_cyc++;
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_en) begin
         if (m_tx_on) chk(m_gap ? "R7 txd" : "R6 txd", txd, m_line);
         else         chk("R8 txd idle", txd, !m_hold);
         chk("R6 tx_busy", tx_busy, m_tx_on);
         chk("R4 rx_valid", rx_valid, m_valid);
         if (m_valid) chk("R3 rx_data", rx_data, m_shift);
         chk("R9 tx_ready", tx_ready,
             !m_tx_on && !m_rx_on && !((m_cyc % DIV) == DIV - 1));
      end
   end

   // ---------------- stimulus
   task automatic send_rx(input logic [7:0] b, input bit check_it, input int idle);
      rxd = 1'b0;
      repeat (BITLEN) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (BITLEN) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (BITLEN) @(negedge clk);
      repeat (idle) @(negedge clk);
      if (check_it) chk("R2 received byte", rx_data, b);
   endtask

   task automatic tx_send(input logic [7:0] b, input bit glitch);
      while (!tx_ready) @(negedge clk);
      tx_data  = b;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      if (glitch) begin
         repeat (40) @(negedge clk);
         rxd = 1'b0;
         repeat (4 * DIV) @(negedge clk);
         rxd = 1'b1;
      end
      while (tx_busy) @(negedge clk);
      chk("R6 line high after stop", txd, 1);
      repeat (2 * DIV) @(negedge clk);
   endtask

   initial begin
      rst_n = 1'b0; rxd = 1'b1; rx_ready = 1'b1; tx_data = '0;
      tx_valid = 1'b0; pull_low = 1'b0;
      repeat (4) @(negedge clk);
      chk("R1 txd in reset", txd, 1);
      chk("R1 rx_valid in reset", rx_valid, 0);
      chk("R1 tx_busy in reset", tx_busy, 0);
      rst_n = 1'b1;
      cmp_en = 1'b1;
      @(negedge clk);
      chk("R1 txd after reset", txd, 1);
      repeat (6) @(negedge clk);

      send_rx(8'hA5, 1'b1, BITLEN);
      tx_send(8'h3C, 1'b0);          // turnaround gap expected (R7)
      tx_send(8'hC3, 1'b0);          // no gap (R6)

      rx_ready = 1'b0;
      send_rx(8'h5A, 1'b1, BITLEN);
      repeat (20) @(negedge clk);
      chk("R5 valid held", rx_valid, 1);
      chk("R5 data held", rx_data, 8'h5A);
      rx_ready = 1'b1;
      @(negedge clk);
      chk("R5 valid cleared", rx_valid, 0);

      tx_send(8'h69, 1'b1);          // low glitch during transmit (R9)
      repeat (40) @(negedge clk);
      chk("R9 no reception during transmit", rx_valid, 0);

      pull_low = 1'b1;
      @(negedge clk);
      pull_low = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 line pulled low", txd, 0);
      repeat (20) @(negedge clk);
      send_rx(8'h81, 1'b1, BITLEN);
      chk("R8 line released by start", txd, 1);

      send_rx(8'h00, 1'b0, 0);
      send_rx(8'hFF, 1'b0, 0);
      send_rx(8'h96, 1'b1, BITLEN);

      tx_send(8'h00, 1'b0);
      tx_send(8'hFF, 1'b0);

      pull_low = 1'b1;
      @(negedge clk);
      pull_low = 1'b0;
      repeat (5) @(negedge clk);
      chk("R8 line pulled low before send", txd, 0);
      tx_send(8'h4B, 1'b0);
      chk("R8 line released by accept", txd, 1);

      repeat (20) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule